// File: doc/BRIEF.md
# Burst Write / Single Read Traffic Driver

This block is a bus master that exercises the local command port of a memory controller with a fixed test pattern. After a start pulse it writes a run of fixed-length write bursts to consecutive word addresses, and then it issues a run of single-word read commands to locations it has just written. Every read response is compared with the value that was written there. A sticky error flag reports any mismatch, and a done flag reports that every response has arrived.

The command side is a valid/ready stream. The write and read strobes act as the valid signal, and the controller's active-high ready input is the back-pressure signal. A beat or command transfers only on a rising clock edge where a strobe and ready are both high. While ready is low, the driver keeps every command output unchanged, including through long stalls such as a controller refresh. The driver never drops a command. It never switches from writing to reading until every beat of the last write burst has transferred. The response side has no back-pressure: each cycle with response-valid high delivers one word, in the same order as the reads.

Top module: `burst_traffic_driver`

## Requirements
- R1: While reset is active, and after reset until start is seen, the write strobe, read strobe, burst-begin, done and error outputs are all low.
- R2: A start pulse takes effect only in the idle state that follows reset. A start pulse while the test runs, or after it has ended, has no effect on the command stream.
- R3: The write phase issues NUM_WBURSTS bursts in order, back to back. Each burst has burst count BURST_LEN. Burst b uses word address b*BURST_LEN, held for all of its beats.
- R4: The data of beat j of burst b is P(b*BURST_LEN + j), where P(a) = (a * 0x9E3779B1 + 0x12345678) mod 2^32.
- R5: Burst-begin is high on exactly the first cycle that each write burst or read command is presented. It is low on every other cycle, including the stalled cycles of that same command.
- R6: While a strobe is high and ready is low, the address, write data, burst count and strobes stay unchanged, and the driver does not advance.
- R7: The write strobe and read strobe are never high together. The first read is presented only after the last beat of the final write burst has transferred.
- R8: The read phase issues NUM_READS single-word reads (burst count 1), in order. Read k uses word address k*S, where S = NUM_WBURSTS*BURST_LEN/NUM_READS (2 by default).
- R9: Response k (counting from 0) is compared with P(k*S). Any mismatch sets error, and error then stays high until reset. Responses after the NUM_READS-th are ignored.
- R10: Done rises on the cycle after the NUM_READS-th response is accepted, and then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts the test sequence from idle |
| cmd_addr | output | ADDR_W | Word address of the current command |
| cmd_write | output | 1 | Write beat valid |
| cmd_read | output | 1 | Read command valid |
| cmd_wdata | output | DATA_W | Write beat data |
| cmd_burstcount | output | clog2(BURST_LEN+1) | Beats in the current command |
| cmd_burst_begin | output | 1 | First cycle of a new command |
| ctrl_ready | input | 1 | Controller accepts the current beat or command (active high) |
| rsp_valid | input | 1 | Read response word valid |
| rsp_data | input | DATA_W | Read response word |
| done | output | 1 | All read responses received (sticky) |
| error | output | 1 | A response mismatched (sticky) |

## Verification
The bound checker tests the cycle-level rules on every clock:
- The command outputs stay frozen under a stall.
- Burst-begin appears once per command.
- The two strobes are never high together.
- No read appears before a whole number of complete bursts, covering all NUM_WBURSTS of them, has transferred.
- The done and error flags are sticky.

The bench's scenarios are needed to show the rest:
- The address and data values and the order of the command stream.
- The response comparison, including a single corrupted word and a late extra word that must be ignored.
- The cycle on which done rises.
- That start pulses in the middle of a run or after it ends are ignored.

These are shown under free-flowing ready, random back-pressure and long refresh-like stalls.

// File: rtl/tdrv_pkg.sv
`timescale 1ns/1ps
package tdrv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_END   = 2'd3
  } tdrv_state_e;

  // Test pattern: word address to 32-bit data word.
  function automatic logic [31:0] pattern32(input logic [31:0] a);
    return a * 32'h9E37_79B1 + 32'h1234_5678;
  endfunction

endpackage

// File: rtl/tdrv_beat_ctr.sv
`timescale 1ns/1ps
// Loadable down-counter holding the beats still owed in the current burst.
module tdrv_beat_ctr #(
  parameter int W        = 3,
  parameter int LOAD_VAL = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         dec,
  output logic [W-1:0] count,
  output logic         is_last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= W'(LOAD_VAL);
    end else if (dec && (count != '0)) begin
      count <= count - W'(1);
    end
  end

  assign is_last = (count == W'(1));

endmodule

// File: rtl/tdrv_cmd_seq.sv
`timescale 1ns/1ps
// Command sequencer: write bursts, then single reads, under ready back-pressure.
module tdrv_cmd_seq
  import tdrv_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int BURST_LEN   = 4,
  parameter int NUM_WBURSTS = 8,
  parameter int NUM_READS   = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic                               ctrl_ready,
  output logic [ADDR_W-1:0]                  cmd_addr,
  output logic                               cmd_write,
  output logic                               cmd_read,
  output logic [DATA_W-1:0]                  cmd_wdata,
  output logic [$clog2(BURST_LEN+1)-1:0]     cmd_burstcount,
  output logic                               cmd_burst_begin
);

  localparam int BEAT_W    = $clog2(BURST_LEN + 1);
  localparam int WB_W      = $clog2(NUM_WBURSTS + 1);
  localparam int RD_W      = $clog2(NUM_READS + 1);
  localparam int RD_STRIDE = (NUM_WBURSTS * BURST_LEN) / NUM_READS;

  tdrv_state_e         state_q;
  logic [WB_W-1:0]     wb_idx_q;
  logic [RD_W-1:0]     rd_idx_q;
  logic                begin_q;

  logic [BEAT_W-1:0]   beats_left;
  logic                beat_last;
  logic                wr_accept;
  logic                rd_accept;
  logic                final_burst;
  logic                final_read;
  logic                load_burst;
  logic [BEAT_W-1:0]   beat_idx;
  logic [31:0]         wr_base;
  logic [31:0]         rd_word;

  assign wr_accept   = (state_q == ST_WRITE) && ctrl_ready;
  assign rd_accept   = (state_q == ST_READ) && ctrl_ready;
  assign final_burst = (wb_idx_q == WB_W'(NUM_WBURSTS - 1));
  assign final_read  = (rd_idx_q == RD_W'(NUM_READS - 1));
  assign load_burst  = ((state_q == ST_IDLE) && start) ||
                       (wr_accept && beat_last && !final_burst);

  tdrv_beat_ctr #(
    .W        (BEAT_W),
    .LOAD_VAL (BURST_LEN)
  ) u_beats (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_burst),
    .dec     (wr_accept),
    .count   (beats_left),
    .is_last (beat_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      wb_idx_q <= '0;
      rd_idx_q <= '0;
      begin_q  <= 1'b0;
    end else begin
      begin_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q  <= ST_WRITE;
            wb_idx_q <= '0;
            begin_q  <= 1'b1;
          end
        end
        ST_WRITE: begin
          if (wr_accept && beat_last) begin
            if (final_burst) begin
              state_q  <= ST_READ;
              rd_idx_q <= '0;
            end else begin
              wb_idx_q <= wb_idx_q + WB_W'(1);
            end
            begin_q <= 1'b1;
          end
        end
        ST_READ: begin
          if (rd_accept) begin
            if (final_read) begin
              state_q <= ST_END;
            end else begin
              rd_idx_q <= rd_idx_q + RD_W'(1);
              begin_q  <= 1'b1;
            end
          end
        end
        default: state_q <= ST_END;
      endcase
    end
  end

  assign beat_idx = BEAT_W'(BURST_LEN) - beats_left;
  assign wr_base  = 32'(wb_idx_q) * 32'(BURST_LEN);
  assign rd_word  = 32'(rd_idx_q) * 32'(RD_STRIDE);

  always_comb begin
    cmd_write       = 1'b0;
    cmd_read        = 1'b0;
    cmd_addr        = '0;
    cmd_wdata       = '0;
    cmd_burstcount  = '0;
    cmd_burst_begin = 1'b0;
    if (state_q == ST_WRITE) begin
      cmd_write       = 1'b1;
      cmd_addr        = wr_base[ADDR_W-1:0];
      cmd_wdata       = DATA_W'(pattern32(wr_base + 32'(beat_idx)));
      cmd_burstcount  = BEAT_W'(BURST_LEN);
      cmd_burst_begin = begin_q;
    end else if (state_q == ST_READ) begin
      cmd_read        = 1'b1;
      cmd_addr        = rd_word[ADDR_W-1:0];
      cmd_burstcount  = BEAT_W'(1);
      cmd_burst_begin = begin_q;
    end
  end

endmodule

// File: rtl/tdrv_rsp_chk.sv
`timescale 1ns/1ps
// In-order read response checker with sticky done and error flags.
module tdrv_rsp_chk
  import tdrv_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int BURST_LEN   = 4,
  parameter int NUM_WBURSTS = 8,
  parameter int NUM_READS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              done,
  output logic              error
);

  localparam int RD_W      = $clog2(NUM_READS + 1);
  localparam int RD_STRIDE = (NUM_WBURSTS * BURST_LEN) / NUM_READS;

  logic [RD_W-1:0]   seen_q;
  logic              take;
  logic [DATA_W-1:0] expect_word;

  assign take        = rsp_valid && (seen_q != RD_W'(NUM_READS));
  assign expect_word = DATA_W'(pattern32(32'(seen_q) * 32'(RD_STRIDE)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      done   <= 1'b0;
      error  <= 1'b0;
    end else if (take) begin
      seen_q <= seen_q + RD_W'(1);
      if (rsp_data != expect_word) begin
        error <= 1'b1;
      end
      if (seen_q == RD_W'(NUM_READS - 1)) begin
        done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/burst_traffic_driver.sv
`timescale 1ns/1ps
// Top: burst write / single read traffic driver for a memory controller port.
module burst_traffic_driver #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int BURST_LEN   = 4,
  parameter int NUM_WBURSTS = 8,
  parameter int NUM_READS   = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  output logic [ADDR_W-1:0]              cmd_addr,
  output logic                           cmd_write,
  output logic                           cmd_read,
  output logic [DATA_W-1:0]              cmd_wdata,
  output logic [$clog2(BURST_LEN+1)-1:0] cmd_burstcount,
  output logic                           cmd_burst_begin,
  input  logic                           ctrl_ready,
  input  logic                           rsp_valid,
  input  logic [DATA_W-1:0]              rsp_data,
  output logic                           done,
  output logic                           error
);

  tdrv_cmd_seq #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .BURST_LEN   (BURST_LEN),
    .NUM_WBURSTS (NUM_WBURSTS),
    .NUM_READS   (NUM_READS)
  ) u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .start           (start),
    .ctrl_ready      (ctrl_ready),
    .cmd_addr        (cmd_addr),
    .cmd_write       (cmd_write),
    .cmd_read        (cmd_read),
    .cmd_wdata       (cmd_wdata),
    .cmd_burstcount  (cmd_burstcount),
    .cmd_burst_begin (cmd_burst_begin)
  );

  tdrv_rsp_chk #(
    .DATA_W      (DATA_W),
    .BURST_LEN   (BURST_LEN),
    .NUM_WBURSTS (NUM_WBURSTS),
    .NUM_READS   (NUM_READS)
  ) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .done      (done),
    .error     (error)
  );

endmodule

// File: rtl/tdrv_sva.sv
`timescale 1ns/1ps
// Protocol checker bound to the traffic driver top.
module tdrv_sva #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int BURST_LEN   = 4,
  parameter int NUM_WBURSTS = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [ADDR_W-1:0]              cmd_addr,
  input logic                           cmd_write,
  input logic                           cmd_read,
  input logic [DATA_W-1:0]              cmd_wdata,
  input logic [$clog2(BURST_LEN+1)-1:0] cmd_burstcount,
  input logic                           cmd_burst_begin,
  input logic                           ctrl_ready,
  input logic                           done,
  input logic                           error
);

  localparam int BW = $clog2(BURST_LEN + 1);
  localparam int NW = $clog2(NUM_WBURSTS + 1);

  logic [BW-1:0] beat_pos;
  logic [NW-1:0] bursts_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_pos    <= '0;
      bursts_done <= '0;
    end else if (cmd_write && ctrl_ready) begin
      if (beat_pos == BW'(BURST_LEN - 1)) begin
        beat_pos <= '0;
        if (bursts_done != NW'(NUM_WBURSTS)) bursts_done <= bursts_done + NW'(1);
      end else begin
        beat_pos <= beat_pos + BW'(1);
      end
    end
  end

  // R5: a stalled command keeps burst-begin for one cycle only
  a_r5_begin_once: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_burst_begin && !ctrl_ready) |=> !cmd_burst_begin);

  // R5: burst-begin only accompanies a command
  a_r5_begin_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_burst_begin |-> (cmd_write || cmd_read));

  // R3: a write burst begins on a burst boundary
  a_r3_begin_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_burst_begin && cmd_write) |-> (beat_pos == '0));

  // R6: stall freezes the command outputs
  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_write || cmd_read) && !ctrl_ready) |=>
      ($stable(cmd_write) && $stable(cmd_read) && $stable(cmd_addr) &&
       $stable(cmd_wdata) && $stable(cmd_burstcount)));

  // R7: strobes mutually exclusive
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_write && cmd_read));

  // R7: reads only after every write burst is complete
  a_r7_read_after_writes: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_read |-> ((beat_pos == '0) && (bursts_done == NW'(NUM_WBURSTS))));

  // R9: error is sticky
  a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);

  // R10: done is sticky
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

endmodule

bind burst_traffic_driver tdrv_sva #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .BURST_LEN   (BURST_LEN),
  .NUM_WBURSTS (NUM_WBURSTS)
) u_sva (
  .clk             (clk),
  .rst_n           (rst_n),
  .cmd_addr        (cmd_addr),
  .cmd_write       (cmd_write),
  .cmd_read        (cmd_read),
  .cmd_wdata       (cmd_wdata),
  .cmd_burstcount  (cmd_burstcount),
  .cmd_burst_begin (cmd_burst_begin),
  .ctrl_ready      (ctrl_ready),
  .done            (done),
  .error           (error)
);

// File: tb/burst_traffic_driver_tb.sv
`timescale 1ns/1ps
module burst_traffic_driver_tb;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int BL = 4;
  localparam int NB = 8;
  localparam int NR = 16;
  localparam int ST = (NB * BL) / NR;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] cmd_addr;
  logic          cmd_write;
  logic          cmd_read;
  logic [DW-1:0] cmd_wdata;
  logic [2:0]    cmd_burstcount;
  logic          cmd_burst_begin;
  logic          ctrl_ready = 1'b0;
  logic          rsp_valid = 1'b0;
  logic [DW-1:0] rsp_data = '0;
  logic          done;
  logic          error;

  always #4 clk = ~clk; // 125 MHz

  burst_traffic_driver u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_read(cmd_read),
    .cmd_wdata(cmd_wdata), .cmd_burstcount(cmd_burstcount),
    .cmd_burst_begin(cmd_burst_begin), .ctrl_ready(ctrl_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done(done), .error(error)
  );

  typedef struct {
    bit          wr;
    bit          first;
    int          addr;
    int          beat;
    logic [31:0] data;
    int          bc;
  } cmd_t;

  cmd_t        exp_q[$];
  int          pend_due[$];
  logic [31:0] pend_dat[$];
  logic [31:0] mem[int];
  bit          head_seen;
  bit          prev_stall;
  bit          started;
  bit          err_exp;
  int          rsp_given;
  int          cyc;
  int          ready_mode;
  int          corrupt_idx;
  int          errors = 0;
  int          checks = 0;

  function automatic logic [31:0] pat(input int a);
    return 32'(a) * 32'h9E37_79B1 + 32'h1234_5678;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic build_queue();
    for (int b = 0; b < NB; b++)
      for (int j = 0; j < BL; j++)
        exp_q.push_back('{1'b1, j == 0, b * BL, j, pat(b * BL + j), BL});
    for (int k = 0; k < NR; k++)
      exp_q.push_back('{1'b0, 1'b1, k * ST, 0, 32'h0, 1});
  endtask

  function automatic bit pick_ready();
    case (ready_mode)
      0: return 1'b1;
      1: return ($urandom_range(3) != 0);
      default: return !((cyc % 23) < 7);
    endcase
  endfunction

  task automatic tick(input bit start_now);
    cmd_t h;
    bit   have;
    bit   rdy;
    logic [31:0] d;
    @(negedge clk);
    cyc++;
    have = (exp_q.size() > 0);
    if (!have) begin
      chk(!cmd_write && !cmd_read && !cmd_burst_begin, started ? "R2" : "R1",
          "no command expected", {cmd_write, cmd_read, cmd_burst_begin}, 0);
    end else begin
      h = exp_q[0];
      chk(cmd_write == h.wr && cmd_read == !h.wr, prev_stall ? "R6" : "R7",
          "strobes", {cmd_write, cmd_read}, {h.wr, !h.wr});
      chk(cmd_addr == AW'(h.addr), prev_stall ? "R6" : (h.wr ? "R3" : "R8"),
          "address", cmd_addr, h.addr);
      chk(cmd_burstcount == 3'(h.bc), h.wr ? "R3" : "R8", "burstcount",
          cmd_burstcount, h.bc);
      if (h.wr)
        chk(cmd_wdata == h.data, prev_stall ? "R6" : "R4", "write data",
            cmd_wdata, h.data);
      chk(cmd_burst_begin == (h.first && !head_seen), "R5", "burst begin",
          cmd_burst_begin, (h.first && !head_seen));
      head_seen = 1'b1;
    end
    chk(done == (rsp_given >= NR), "R10", "done", done, (rsp_given >= NR));
    chk(error == err_exp, "R9", "error", error, err_exp);

    rdy = pick_ready();
    ctrl_ready = rdy;
    prev_stall = have && !rdy;
    if (have && rdy) begin
      if (h.wr) mem[h.addr + h.beat] = cmd_wdata;
      else begin
        pend_due.push_back(cyc + 2);
        pend_dat.push_back(mem.exists(h.addr) ? mem[h.addr] : 32'h0);
      end
      void'(exp_q.pop_front());
      head_seen = 1'b0;
    end

    if (pend_due.size() > 0 && pend_due[0] <= cyc) begin
      void'(pend_due.pop_front());
      d = pend_dat.pop_front();
      if (rsp_given == corrupt_idx) d = d ^ 32'h1;
      if (rsp_given < NR && d != pat(rsp_given * ST)) err_exp = 1'b1;
      rsp_valid = 1'b1;
      rsp_data  = d;
      rsp_given++;
    end else begin
      rsp_valid = 1'b0;
      rsp_data  = $urandom;
    end

    start = start_now;
    if (start_now && !started) begin
      build_queue();
      started = 1'b1;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; ctrl_ready = 1'b0; rsp_valid = 1'b0;
    exp_q.delete(); pend_due.delete(); pend_dat.delete(); mem.delete();
    head_seen = 0; prev_stall = 0; started = 0; err_exp = 0; rsp_given = 0;
    repeat (3) @(negedge clk);
    chk(!cmd_write && !cmd_read && !cmd_burst_begin && !done && !error, "R1",
        "outputs in reset", {cmd_write, cmd_read, cmd_burst_begin, done, error}, 0);
    rst_n = 1'b1;
  endtask

  task automatic run(input int mode, input int corrupt);
    int n;
    do_reset();
    ready_mode  = mode;
    corrupt_idx = corrupt;
    repeat (4) tick(1'b0);
    tick(1'b1);
    n = 0;
    while (!(rsp_given >= NR && exp_q.size() == 0 && pend_due.size() == 0) && n < 4000) begin
      tick(n == 10); // R2: start mid-run ignored
      n++;
    end
    chk(n < 4000, "R10", "run completes", n, 4000);
    repeat (3) tick(1'b0);
    // R9: a response after the last one is ignored
    pend_due.push_back(cyc);
    pend_dat.push_back(32'hDEAD_BEEF);
    tick(1'b0);
    tick(1'b1); // R2: start after the end ignored
    repeat (3) tick(1'b0);
    chk(done == 1'b1, "R10", "done at end", done, 1);
    chk(error == (corrupt >= 0), "R9", "error at end", error, (corrupt >= 0));
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    run(0, -1); // free-flowing ready
    run(1, 5);  // random back-pressure, corrupted response 5
    run(2, -1); // refresh-like stalls
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule